// File: doc/BRIEF.md
# Byte-Write Completion Engine

This block sits on the programming-master side of a serial in-system programming link. It takes one byte write to a target's flash or EEPROM, issues the write as a four-byte command to an SPI shifter, and then decides when the target is free to take the next command. Each request chooses between two ways of judging completion. In poll mode the engine reads the same location back over and over until the returned byte equals the value written. In delay mode it waits a fixed number of clock cycles.

While a target programs a byte, a readback of that location returns a busy marker (all ones by default). When the written value is itself that marker, a readback cannot show whether the write has finished. For such a write the engine ignores the poll request and uses the fixed delay. In poll mode the same delay figure acts as a timeout. When a mismatching readback arrives after that time has run out, the engine ends the write with an error. Only one write is in flight at any time.

Each command has four bytes. Byte 1 is the opcode, bytes 2 and 3 are the address (high byte, then low byte) and byte 4 is data. The shifter takes a command through a valid/ready handshake and later returns the byte it received during the fourth transfer.

Top module: `wpoll_engine`

## Requirements
- R1: While reset is asserted and right after it is released, reqReady is 1 and cmdValid, done and err are 0.
- R2: An accepted request first issues a write command. cmdBytes[31:24] is the opcode: 0x40 for the low flash byte, 0x48 for the high flash byte (the H bit at bit 3), and 0xC0 for EEPROM, where reqHigh is ignored. cmdBytes[23:8] is the address, high byte first, and cmdBytes[7:0] is the data.
- R3: In poll mode, after the write response, the engine issues read commands. The opcode is 0x20 for the low flash byte, 0x28 for the high flash byte and 0xA0 for EEPROM, with the same address bytes and 0x00 in cmdBytes[7:0]. Only one command is in flight at a time.
- R4: A poll ends with done=1 and err=0 in the cycle after a read response whose rspData equals the written data. A mismatching response that arrives before the timeout triggers another read.
- R5: When the written data equals the busy marker 0xFF, the engine issues no reads even when poll mode is selected, and the write completes on delay-mode timing.
- R6: In delay mode, done rises exactly reqDelay+2 clock cycles after the cycle in which the write response is presented.
- R7: A mismatching read response taken reqDelay+1 or more cycles after the write response ends the write with done=1 and err=1. A matching response always completes without error, even if it arrives after the timeout.
- R8: reqReady is 0 from acceptance until done. A reqValid presented while reqReady is 0 starts no command. reqReady returns one cycle after done.
- R9: done is a single-cycle pulse, and err is 1 only while done is 1.
- R10: A command that has not been accepted keeps cmdValid at 1 and cmdBytes unchanged until cmdReady is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request strobe |
| reqReady | output | 1 | Engine idle; a request can be accepted |
| reqMem | input | 1 | Target memory: 0 flash, 1 EEPROM |
| reqHigh | input | 1 | Flash byte half: 0 low, 1 high |
| reqAddr | input | ADDR_W | Location address |
| reqData | input | 8 | Byte to write |
| reqPoll | input | 1 | 1 poll mode, 0 delay mode |
| reqDelay | input | CNT_W | Delay / poll timeout in clock cycles |
| cmdValid | output | 1 | Command offered to the shifter |
| cmdReady | input | 1 | Shifter accepts the command |
| cmdBytes | output | 32 | Four command bytes, first byte in bits 31:24 |
| rspValid | input | 1 | Shifter finished a command |
| rspData | input | 8 | Byte received in the fourth transfer |
| done | output | 1 | Completion pulse |
| err | output | 1 | Poll timeout, valid with done |

## Verification
A table of writes covers flash low and high halves and EEPROM. For each write the bench measures the write-response-to-done latency and the number of reads issued, and it checks the bytes of every command. Poll cases that succeed after zero, two and five busy readbacks check that the engine keeps polling and also stops once the byte matches. Targets stuck on the marker, with timeouts aligned both on and off the read rhythm, pin down exactly which readback raises the error. One case has a match land on the very response where the timeout expires, which shows that a match takes priority. A marker-valued write in poll mode separates a true fallback (no reads, delay timing) from a naive poll, which would stop at once on a false match. Directed tests hold back cmdReady and send a second request while busy.

// File: rtl/wpoll_pkg.sv
package wpoll_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 4 * BYTE_W;
  localparam int HALF_BIT = 3;

  localparam logic [BYTE_W-1:0] OP_FLASH_WR = 8'h40;
  localparam logic [BYTE_W-1:0] OP_FLASH_RD = 8'h20;
  localparam logic [BYTE_W-1:0] OP_EE_WR    = 8'hC0;
  localparam logic [BYTE_W-1:0] OP_EE_RD    = 8'hA0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_SEND,
    ST_WR_WAIT,
    ST_DELAY,
    ST_RD_SEND,
    ST_RD_WAIT,
    ST_FIN
  } wpState_e;

  typedef struct packed {
    logic latchReq;
    logic clrCnt;
    logic incCnt;
    logic selRead;
    logic setErr;
  } wpStrobe_t;
endpackage

// File: rtl/wpoll_datapath.sv
module wpoll_datapath
  import wpoll_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter logic [7:0] BUSY_MARK = 8'hFF
) (
  input  logic                clk,
  input  logic                rstN,
  input  wpStrobe_t           strobe,
  input  logic                reqMem,
  input  logic                reqHigh,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [BYTE_W-1:0]   reqData,
  input  logic                reqPoll,
  input  logic [CNT_W-1:0]    reqDelay,
  input  logic [BYTE_W-1:0]   rspData,
  output logic [CMD_W-1:0]    cmdBytes,
  output logic                useDelay,
  output logic                timeUp,
  output logic                match,
  output logic                errFlag
);
  localparam int WIDE_ADDR = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic                memQ;
  logic                highQ;
  logic [ADDR_W-1:0]   addrQ;
  logic [BYTE_W-1:0]   dataQ;
  logic                pollQ;
  logic [CNT_W-1:0]    delayQ;
  logic [CNT_W-1:0]    cnt;
  logic [WIDE_ADDR-1:0] addrWide;
  logic [BYTE_W-1:0]   wrOp;
  logic [BYTE_W-1:0]   rdOp;
  logic [BYTE_W-1:0]   halfMask;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memQ   <= 1'b0;
      highQ  <= 1'b0;
      addrQ  <= '0;
      dataQ  <= '0;
      pollQ  <= 1'b0;
      delayQ <= '0;
    end else if (strobe.latchReq) begin
      memQ   <= reqMem;
      highQ  <= reqHigh;
      addrQ  <= reqAddr;
      dataQ  <= reqData;
      pollQ  <= reqPoll;
      delayQ <= reqDelay;
    end
  end

  // shared delay / timeout counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.clrCnt) begin
      cnt <= '0;
    end else if (strobe.incCnt && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // error flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (strobe.latchReq) begin
      errFlag <= 1'b0;
    end else if (strobe.setErr) begin
      errFlag <= 1'b1;
    end
  end

  // opcode build: the half-select bit only exists for flash
  always_comb begin
    halfMask = '0;
    halfMask[HALF_BIT] = highQ;
    if (memQ) begin
      wrOp = OP_EE_WR;
      rdOp = OP_EE_RD;
    end else begin
      wrOp = OP_FLASH_WR | halfMask;
      rdOp = OP_FLASH_RD | halfMask;
    end
  end

  assign addrWide = WIDE_ADDR'(addrQ);

  always_comb begin
    if (strobe.selRead) begin
      cmdBytes = {rdOp, addrWide, {BYTE_W{1'b0}}};
    end else begin
      cmdBytes = {wrOp, addrWide, dataQ};
    end
  end

  assign useDelay = !pollQ || (dataQ == BUSY_MARK);
  assign timeUp   = (cnt >= delayQ);
  assign match    = (rspData == dataQ);
endmodule

// File: rtl/wpoll_ctrl.sv
module wpoll_ctrl
  import wpoll_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      cmdReady,
  input  logic      rspValid,
  input  logic      useDelay,
  input  logic      timeUp,
  input  logic      match,
  output wpStrobe_t strobe,
  output logic      reqReady,
  output logic      cmdValid,
  output logic      done
);
  wpState_e state;
  wpState_e nextState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    reqReady  = 1'b0;
    cmdValid  = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          nextState = ST_WR_SEND;
        end
      end
      ST_WR_SEND: begin
        cmdValid = 1'b1;
        if (cmdReady) nextState = ST_WR_WAIT;
      end
      ST_WR_WAIT: begin
        if (rspValid) begin
          strobe.clrCnt = 1'b1;
          nextState = useDelay ? ST_DELAY : ST_RD_SEND;
        end
      end
      ST_DELAY: begin
        if (timeUp) begin
          nextState = ST_FIN;
        end else begin
          strobe.incCnt = 1'b1;
        end
      end
      ST_RD_SEND: begin
        cmdValid = 1'b1;
        strobe.selRead = 1'b1;
        strobe.incCnt = 1'b1;
        if (cmdReady) nextState = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        strobe.selRead = 1'b1;
        strobe.incCnt = 1'b1;
        if (rspValid) begin
          if (match) begin
            nextState = ST_FIN;
          end else if (timeUp) begin
            strobe.setErr = 1'b1;
            nextState = ST_FIN;
          end else begin
            nextState = ST_RD_SEND;
          end
        end
      end
      ST_FIN: begin
        done = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/wpoll_engine.sv
module wpoll_engine
  import wpoll_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter logic [7:0] BUSY_MARK = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqMem,
  input  logic              reqHigh,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic              reqPoll,
  input  logic [CNT_W-1:0]  reqDelay,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [31:0]       cmdBytes,
  input  logic              rspValid,
  input  logic [7:0]        rspData,
  output logic              done,
  output logic              err
);
  wpStrobe_t strobe;
  logic useDelay;
  logic timeUp;
  logic match;
  logic errFlag;

  wpoll_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cmdReady (cmdReady),
    .rspValid (rspValid),
    .useDelay (useDelay),
    .timeUp   (timeUp),
    .match    (match),
    .strobe   (strobe),
    .reqReady (reqReady),
    .cmdValid (cmdValid),
    .done     (done)
  );

  wpoll_datapath #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .BUSY_MARK (BUSY_MARK)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqMem   (reqMem),
    .reqHigh  (reqHigh),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .reqPoll  (reqPoll),
    .reqDelay (reqDelay),
    .rspData  (rspData),
    .cmdBytes (cmdBytes),
    .useDelay (useDelay),
    .timeUp   (timeUp),
    .match    (match),
    .errFlag  (errFlag)
  );

  assign err = done && errFlag;
endmodule

// File: rtl/wpoll_engine_chk.sv
module wpoll_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [7:0]  reqData,
  input logic        cmdValid,
  input logic        cmdReady,
  input logic [31:0] cmdBytes,
  input logic        done,
  input logic        err
);
  // R2: the first command after acceptance carries the requested data byte
  a_r2_write_first: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (cmdValid && (cmdBytes[7:0] == $past(reqData))));

  // R8: never idle while a command is on offer
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !reqReady);

  // R8: ready returns right after completion
  a_r8_ready_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady);

  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: error only alongside done
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  // R10: an unaccepted command holds
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdBytes)));
endmodule

bind wpoll_engine wpoll_engine_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqData  (reqData),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .cmdBytes (cmdBytes),
  .done     (done),
  .err      (err)
);

// File: tb/wpoll_engine_test.sv
`timescale 1ns/1ps
module wpoll_engine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqMem = 1'b0;
  logic        reqHigh = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic        reqPoll = 1'b0;
  logic [15:0] reqDelay = '0;
  logic        cmdValid;
  logic        cmdReady = 1'b1;
  logic [31:0] cmdBytes;
  logic        rspValid = 1'b0;
  logic [7:0]  rspData = '0;
  logic        done;
  logic        err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // target model state
  int          wrCount = 0;
  int          rdCount = 0;
  logic [31:0] lastWr = '0;
  logic [31:0] lastRd = '0;
  logic [7:0]  memVal = '0;
  int          busyLeft = 0;
  logic        stuck = 1'b0;
  int          pendCnt = 0;
  logic [7:0]  pendData = '0;
  logic        pendIsWr = 1'b0;
  int          wrRspCyc = 0;

  wpoll_engine uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqMem(reqMem), .reqHigh(reqHigh), .reqAddr(reqAddr), .reqData(reqData),
    .reqPoll(reqPoll), .reqDelay(reqDelay), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdBytes(cmdBytes), .rspValid(rspValid),
    .rspData(rspData), .done(done), .err(err)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // shifter + target model: response two cycles after acceptance
  always @(negedge clk) begin
    rspValid = 1'b0;
    if (pendCnt > 0) begin
      pendCnt = pendCnt - 1;
      if (pendCnt == 0) begin
        rspValid = 1'b1;
        rspData = pendData;
        if (pendIsWr) wrRspCyc = cyc;
      end
    end
    if (cmdValid && cmdReady) begin
      pendCnt = 2;
      if (cmdBytes[29]) begin
        rdCount = rdCount + 1;
        lastRd = cmdBytes;
        pendIsWr = 1'b0;
        if (stuck || busyLeft > 0) begin
          pendData = 8'hFF;
          if (busyLeft > 0) busyLeft = busyLeft - 1;
        end else begin
          pendData = memVal;
        end
      end else begin
        wrCount = wrCount + 1;
        lastWr = cmdBytes;
        memVal = cmdBytes[7:0];
        pendIsWr = 1'b1;
        pendData = cmdBytes[15:8];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        mem;
    logic        high;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        poll;
    logic [15:0] dly;
    logic [7:0]  busy;
    logic        stk;
    logic        expErr;
    logic [7:0]  expReads;
    logic [15:0] expLat;
    logic [7:0]  expWrOp;
    logic [7:0]  expRdOp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b0,16'h0104,8'h3C,1'b1,16'd200,8'd2,1'b0,1'b0,8'd3,16'd10,8'h40,8'h20},
    '{1'b0,1'b1,16'h010C,8'h0F,1'b1,16'd200,8'd0,1'b0,1'b0,8'd1,16'd4, 8'h48,8'h28},
    '{1'b1,1'b0,16'h0011,8'h5A,1'b0,16'd7,  8'd0,1'b0,1'b0,8'd0,16'd9, 8'hC0,8'h00},
    '{1'b1,1'b0,16'h003F,8'hFF,1'b1,16'd12, 8'd0,1'b0,1'b0,8'd0,16'd14,8'hC0,8'h00},
    '{1'b0,1'b0,16'h0200,8'h77,1'b1,16'd10, 8'd0,1'b1,1'b1,8'd4,16'd13,8'h40,8'h20},
    '{1'b1,1'b1,16'h0123,8'h81,1'b1,16'd0,  8'd0,1'b0,1'b0,8'd1,16'd4, 8'hC0,8'hA0},
    '{1'b0,1'b1,16'h0FFE,8'h00,1'b0,16'd0,  8'd0,1'b0,1'b0,8'd0,16'd2, 8'h48,8'h00},
    '{1'b1,1'b0,16'h0100,8'hE7,1'b1,16'd50, 8'd5,1'b0,1'b0,8'd6,16'd19,8'hC0,8'hA0},
    '{1'b0,1'b1,16'h0033,8'h10,1'b1,16'd12, 8'd0,1'b1,1'b1,8'd5,16'd16,8'h48,8'h28},
    '{1'b1,1'b0,16'h0007,8'h3E,1'b1,16'd11, 8'd3,1'b0,1'b0,8'd4,16'd13,8'hC0,8'hA0}
  };

  int   doneCyc;
  logic errSeen;

  task automatic runReq(input vec_t v);
    wrCount = 0; rdCount = 0; busyLeft = int'(v.busy); stuck = v.stk;
    @(negedge clk);
    reqMem = v.mem; reqHigh = v.high; reqAddr = v.addr; reqData = v.data;
    reqPoll = v.poll; reqDelay = v.dly; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    doneCyc = cyc;
    errSeen = err;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reqReady in reset", 32'(reqReady), 32'd1);
    chk("R1 cmdValid in reset", 32'(cmdValid), 32'd0);
    chk("R1 done/err in reset", {30'd0, done, err}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {29'd0, reqReady, cmdValid, done}, 32'd4);

    foreach (VECS[k]) begin
      vec_t v;
      string latTag;
      v = VECS[k];
      runReq(v);
      if (!v.poll) latTag = "R6 delay latency";
      else if (v.data == 8'hFF) latTag = "R5 marker fallback latency";
      else if (v.expErr) latTag = "R7 timeout latency";
      else latTag = "R4 poll latency";
      chk($sformatf("%s vec%0d", latTag, k), 32'(doneCyc - wrRspCyc), 32'(v.expLat));
      chk($sformatf("R7 err flag vec%0d", k), 32'(errSeen), 32'(v.expErr));
      chk($sformatf("R3 R5 read count vec%0d", k), 32'(rdCount), 32'(v.expReads));
      chk($sformatf("R2 write bytes vec%0d", k), lastWr, {v.expWrOp, v.addr, v.data});
      chk($sformatf("R2 single write vec%0d", k), 32'(wrCount), 32'd1);
      if (v.expReads != 0)
        chk($sformatf("R3 read bytes vec%0d", k), lastRd, {v.expRdOp, v.addr, 8'h00});
      @(negedge clk);
      chk($sformatf("R9 done pulse ends vec%0d", k), {30'd0, done, err}, 32'd0);
      chk($sformatf("R8 ready after done vec%0d", k), 32'(reqReady), 32'd1);
    end

    // R8: request while busy is ignored
    wrCount = 0; rdCount = 0; busyLeft = 0; stuck = 1'b0;
    @(negedge clk);
    reqMem = 1'b1; reqHigh = 1'b0; reqAddr = 16'h0042; reqData = 8'h42;
    reqPoll = 1'b0; reqDelay = 16'd30; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 not ready while busy", 32'(reqReady), 32'd0);
    reqData = 8'h99; reqAddr = 16'h0099; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 500; i++) begin
      if (done) break;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk("R8 ignored request issued nothing", 32'(wrCount + rdCount), 32'd1);
    chk("R8 kept original write", lastWr, {8'hC0, 16'h0042, 8'h42});

    // R10: command held while the shifter stalls
    wrCount = 0; rdCount = 0;
    @(negedge clk);
    cmdReady = 1'b0;
    reqMem = 1'b0; reqHigh = 1'b1; reqAddr = 16'h0ABC; reqData = 8'h5D;
    reqPoll = 1'b1; reqDelay = 16'd100; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 cmdValid held", 32'(cmdValid), 32'd1);
    chk("R10 cmdBytes held", cmdBytes, {8'h48, 16'h0ABC, 8'h5D});
    chk("R10 nothing accepted", 32'(wrCount), 32'd0);
    cmdReady = 1'b1;
    for (int i = 0; i < 500; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R4 poll after stall succeeds", {30'd0, done, err}, 32'd2);
    chk("R3 read after stall", lastRd, {8'h28, 16'h0ABC, 8'h00});
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule